// File: doc/BRIEF.md
# Chainable Converter Serial Output Port

This block is the digital side of a sampling converter's serial output when the converter runs in its chainable mode with no busy indicator. A host raises the convert line while the serial clock is low. That edge starts a conversion and selects the mode. A parameterised count of system clocks stands in for the conversion time. When the count runs out, the parallel result word is loaded into an internal shift register, and its most significant bit appears on the serial output without any serial clock edge.

Each later falling edge of the serial clock moves the word one place towards the output. At the same edge the serial input enters at the far end. Several ports can therefore be wired output-to-input and read as one long shift register. The device furthest from the host has its serial input tied low. The host reads the nearest device's word first, then the next device's word, and so on, using the word width times the device count in falling edges. Dropping the convert line ends the readout.

The serial lines are treated as levels that are already synchronous to the system clock. Their edges are found by comparing each sample with the one before.

Top module: `chain_sdo_port`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the port is idle and `sdo` is 0.
- R2: Outside a readout, and in particular whenever `cnv` and `sdi` are both low, `sdo` is held at 0.
- R3: A `cnv` rising edge sampled while `sck` is low starts a conversion. A `cnv` rising edge sampled while `sck` is high starts nothing, and `sdo` stays 0.
- R4: Exactly `CONV_CYCLES` system clocks after the `cnv` rising edge is sampled, `sdo` shows bit 13 (the MSB) of the loaded result, with no `sck` edge needed. One clock earlier, `sdo` is still 0.
- R5: Falling edges of `sck` during the conversion are ignored. The word presented afterwards is complete and starts with its MSB.
- R6: After the MSB, each `sck` falling edge presents the next lower result bit on `sdo`, so bits 13 down to 0 are read before falling edges 1 to 14.
- R7: Each `sck` falling edge in a readout shifts `sdi` into bit 0 of the register. In a chain of two ports with the upstream `sdi` tied low, 28 falling edges deliver the downstream word and then the upstream word, both MSB first, followed by zeros.
- R8: A `cnv` falling edge ends the readout, and `sdo` returns to 0 on the following cycle.
- R9: The result is captured when the conversion ends, not when it starts. A value placed on `result` during the conversion is the one shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv | input | 1 | Convert line: its rising edge starts a conversion, and holding it high keeps the readout open |
| sck | input | 1 | Serial clock: its level at the `cnv` rise selects the mode, and its falling edges shift the register |
| sdi | input | 1 | Serial input from the upstream device in the chain |
| result | input | RES_W | Parallel conversion result, captured when the conversion ends |
| sdo | output | 1 | Serial output towards the host or the downstream device |

## Verification
The assertions assume that `cnv`, `sck` and `sdi` change only between system clock edges. They also assume each level is held for at least one clock, so every edge is seen as one sampled transition. Under these conditions the checker can pair each shift with the `sdi` value it saw one sample earlier.

The stimulus drives every input on the falling edge of the system clock and holds each `sck` phase for two clocks. It raises `cnv` only while the port is idle. The bench instantiates two ports with one port's output wired to the other's input, so the chain input changes only through the upstream register.

// File: rtl/chain_port_pkg.sv
// Package: shared types for the chainable serial output port.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package chain_port_pkg;

    // Phases of one conversion-and-readout cycle
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_READ = 2'd2
    } port_state_e;

endpackage

// File: rtl/line_sampler.sv
// Module: line_sampler
// Keeps the previous sampled level of each input line so that the parent
// can form rising and falling edges. Assumes the lines are already
// synchronous to clk. Reset sets every previous level to 0.
module line_sampler #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl,
    output logic [LINES-1:0] prev
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Purpose: remember one line's level from the previous cycle
        always_ff @(posedge clk) begin
            if (!rst_n) prev[g] <= 1'b0;
            else        prev[g] <= lvl[g];
        end
    end

endmodule

// File: rtl/conv_timer.sv
// Module: conv_timer
// Stands in for the conversion time. After start it counts CONV_CYCLES
// clocks and raises done for one cycle on the last one. An abort clears it.
// Assumes CONV_CYCLES >= 1 and that start is raised only while idle.
module conv_timer #(
    parameter int CONV_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic done
);

    localparam int CW = $clog2(CONV_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // Purpose: load, decrement and stop the conversion counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= LAST;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Purpose: flag the final cycle of the conversion
    always_comb done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/result_shifter.sv
// Module: result_shifter
// Parallel-load, serial-shift register. A load wins over a shift. A shift
// moves the word towards the MSB and takes din into bit 0.
// Assumes load and shift are single-cycle strobes.
module result_shifter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic         din,
    input  logic [W-1:0] par,
    output logic [W-1:0] word
);

    // Purpose: hold the word being sent out and accept upstream bits
    always_ff @(posedge clk) begin
        if (!rst_n)     word <= '0;
        else if (load)  word <= par;
        else if (shift) word <= {word[W-2:0], din};
    end

endmodule

// File: rtl/chain_sdo_port.sv
// Module: chain_sdo_port (top)
// Serial output port of one converter in chainable mode with no busy
// indicator. A cnv rising edge seen while sck is low starts a conversion.
// When the conversion ends the result is loaded and its MSB is driven.
// sck falling edges then shift the word out while sdi enters behind it.
// A cnv falling edge ends the cycle. Assumes cnv, sck and sdi are
// synchronous to clk and each level is held for at least one clock.
module chain_sdo_port
    import chain_port_pkg::*;
#(
    parameter int RES_W       = 14,
    parameter int CONV_CYCLES = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnv,
    input  logic             sck,
    input  logic             sdi,
    input  logic [RES_W-1:0] result,
    output logic             sdo
);

    localparam int LINE_CNV = 0;
    localparam int LINE_SCK = 1;

    port_state_e      state_q, state_d;
    logic [1:0]       line_prev;
    logic             cnv_rise, cnv_fall, sck_fall;
    logic             conv_start, conv_done, word_load, word_shift;
    logic [RES_W-1:0] shift_word;

    line_sampler #(.LINES(2)) u_lines (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({sck, cnv}),
        .prev  (line_prev)
    );

    // Purpose: form the edges of the convert and serial clock lines
    always_comb begin
        cnv_rise = cnv && !line_prev[LINE_CNV];
        cnv_fall = !cnv && line_prev[LINE_CNV];
        sck_fall = !sck && line_prev[LINE_SCK];
    end

    // Purpose: decide starts, loads and shifts for this cycle
    always_comb begin
        conv_start = (state_q == ST_IDLE) && cnv_rise && !sck;
        word_load  = (state_q == ST_CONV) && conv_done && !cnv_fall;
        word_shift = (state_q == ST_READ) && sck_fall && !cnv_fall;
    end

    conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .abort (cnv_fall),
        .done  (conv_done)
    );

    result_shifter #(.W(RES_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (word_load),
        .shift (word_shift),
        .din   (sdi),
        .par   (result),
        .word  (shift_word)
    );

    // Purpose: next phase of the conversion-and-readout cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (conv_start) state_d = ST_CONV;
            ST_CONV: begin
                if (cnv_fall)       state_d = ST_IDLE;
                else if (conv_done) state_d = ST_READ;
            end
            ST_READ: if (cnv_fall) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: drive the register MSB only during a readout, else low
    always_comb sdo = (state_q == ST_READ) && shift_word[RES_W-1];

endmodule

// File: rtl/chain_sdo_port_chk.sv
// Module: chain_sdo_port_chk
// Assertion checker for chain_sdo_port, attached with a bind. It keeps its
// own copy of the previous line levels. Assumes the inputs change only
// between clock edges.
module chain_sdo_port_chk
    import chain_port_pkg::*;
#(
    parameter int RES_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnv,
    input logic             sck,
    input logic             sdi,
    input logic             sdo,
    input logic [RES_W-1:0] result,
    input port_state_e      state,
    input logic [RES_W-1:0] word
);

    logic cnv_p, sck_p;

    // Purpose: previous line levels seen by the checker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_p <= 1'b0;
            sck_p <= 1'b0;
        end else begin
            cnv_p <= cnv;
            sck_p <= sck;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> state == ST_IDLE); // R1
    AST_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cnv) |-> !sdo); // R2
    AST_START_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cnv && !cnv_p && !sck) |=> state == ST_CONV); // R3
    AST_NO_START_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && sck) |=> state == ST_IDLE); // R3
    AST_LOAD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_CONV && state == ST_READ) |-> word == $past(result)); // R9
    AST_CONV_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CONV |=> (state == ST_READ || $stable(word))); // R5
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && cnv && !sck && sck_p)
        |=> word == {$past(word[RES_W-2:0]), $past(sdi)}); // R7
    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && cnv && !(!sck && sck_p)) |=> $stable(word)); // R6
    AST_END_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && !cnv && cnv_p) |=> state == ST_IDLE); // R8

endmodule

bind chain_sdo_port chain_sdo_port_chk #(.RES_W(RES_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnv    (cnv),
    .sck    (sck),
    .sdi    (sdi),
    .sdo    (sdo),
    .result (result),
    .state  (state_q),
    .word   (shift_word)
);

// File: tb/test_chain_sdo_port.sv
// Bench: two chained ports (i_chain_sdo_port_up feeds i_chain_sdo_port).
// A driver pushes expected bits into a queue; a monitor compares them.
module test_chain_sdo_port;

    localparam int W = 14;
    localparam int C = 20;

    typedef struct {
        logic  exp;
        bit    from_up;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnv = 1'b0, sck = 1'b0, sdi_up = 1'b0;
    logic [W-1:0] res_up = '0, res_dn = '0;
    logic         sdo_up, sdo_dn;
    int           checks = 0, failures = 0;
    bit           done = 1'b0;
    exp_t         sb_q[$];
    event         sample_ev;

    always #4 clk = ~clk;

    chain_sdo_port #(.RES_W(W), .CONV_CYCLES(C)) i_chain_sdo_port_up (
        .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi_up),
        .result(res_up), .sdo(sdo_up));

    chain_sdo_port #(.RES_W(W), .CONV_CYCLES(C)) i_chain_sdo_port (
        .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdo_up),
        .result(res_dn), .sdo(sdo_dn));

    // Monitor: pops expected items and compares them with the port outputs
    task automatic drain();
        while (sb_q.size() > 0) begin
            exp_t it = sb_q.pop_front();
            logic got = it.from_up ? sdo_up : sdo_dn;
            checks++;
            if (got !== it.exp) begin
                failures++;
                $display("FAIL %s: sdo%s got %0b expected %0b", it.tag,
                         it.from_up ? "_up" : "_dn", got, it.exp);
            end
        end
    endtask

    initial forever begin
        @(sample_ev);
        drain();
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_bit(bit from_up, logic exp, string tag);
        exp_t it;
        it.exp = exp; it.from_up = from_up; it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic sck_pulse();
        sck = 1'b1; tick(2);
        sck = 1'b0; tick(2);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] chain;
        tick(3);
        expect_bit(0, 1'b0, "R1 in reset");
        expect_bit(1, 1'b0, "R1 in reset");
        rst_n = 1'b1; tick(1);
        expect_bit(0, 1'b0, "R1 after reset");
        expect_bit(1, 1'b0, "R2 cnv and sdi low");

        // R3: rising cnv while sck is high starts nothing
        res_up = 14'h3FFF; res_dn = 14'h3FFF;
        sck = 1'b1; tick(1);
        cnv = 1'b1; tick(C + 4);
        expect_bit(0, 1'b0, "R3 sck high no start");
        expect_bit(1, 1'b0, "R3 sck high no start");
        cnv = 1'b0; tick(2);
        sck = 1'b0; tick(2);

        // Main chained readout; sck falls during conversion (R5)
        res_up = 14'h0001; res_dn = 14'h0002;
        cnv = 1'b1; tick(2);
        sck_pulse(); sck_pulse(); sck_pulse();
        res_up = 14'h2A5C; res_dn = 14'h3C3B;   // R9: captured at the end
        tick(C - 14);
        expect_bit(0, 1'b0, "R4 one clock early");
        tick(1);
        expect_bit(0, 1'b1, "R4 MSB at conversion end");
        chain = {res_dn, res_up};
        for (int i = 0; i < 2 * W; i++) begin
            expect_bit(0, chain[2*W-1-i], i < W ? "R6 R5 R9 own word" : "R7 upstream word");
            sck_pulse();
        end
        expect_bit(0, 1'b0, "R7 zeros after chain");
        cnv = 1'b0; tick(2);
        expect_bit(0, 1'b0, "R8 readout ended");
        expect_bit(1, 1'b0, "R8 readout ended");

        // Second cycle: upstream sdi high, cnv dropped mid-readout
        res_up = 14'h0F0F; res_dn = 14'h1234; sdi_up = 1'b1;
        tick(2);
        cnv = 1'b1; tick(C + 1);
        for (int i = 0; i < W + 2; i++) begin
            expect_bit(1, i < W ? res_up[W-1-i] : 1'b1, "R7 sdi shifted in");
            expect_bit(0, i < W ? res_dn[W-1-i] : res_up[W-1-(i-W)], "R6 downstream");
            sck_pulse();
        end
        cnv = 1'b0; tick(2);
        expect_bit(1, 1'b0, "R8 R2 low after cnv fall");
        expect_bit(0, 1'b0, "R8 low after cnv fall");
        sdi_up = 1'b0;

        tick(2);
        drain();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule